// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is the combinational arithmetic and logic unit of a 32-bit integer datapath. It takes two operands and a 4-bit operation code. In the same cycle it returns a result word and three flags: a zero indication, a signed overflow indication and the carry out of the top bit. The register-read stage feeds it directly. Branch logic uses the zero flag to decide equal and not-equal branches.

The unit is built from one 1-bit slice, repeated once per bit. Each slice holds an optional inverter on each operand input, an AND gate, an OR gate, a full adder and a four-way result selector. The adders form a ripple-carry chain.

There is no dedicated subtractor or NOR gate. Subtraction inverts the second operand and injects a carry of one into bit 0. NOR inverts both operands and takes the AND path. Signed less-than runs a subtraction and routes a comparison bit, built from the top bit, back into the least significant slice.

Top module: `alu32_bitslice`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of `a` and `b`.
- R2: Code 4'b0001 returns the bitwise OR of `a` and `b`.
- R3: Code 4'b1100 returns the bitwise NOR of `a` and `b`.
- R4: Code 4'b0010 returns `a + b` modulo 2^32, and `carry_out` is the carry out of bit 31.
- R5: Code 4'b0110 returns `a - b` modulo 2^32, and `carry_out` is 1 exactly when `a >= b` as unsigned numbers (no borrow).
- R6: For codes 4'b0010 and 4'b0110, `overflow` is 1 exactly when the signed result does not fit in 32 bits. For addition, that is two same-sign operands giving a result of the other sign. For subtraction, that is operands of different sign giving a result whose sign differs from `a`.
- R7: For every code other than 4'b0010 and 4'b0110, `overflow` is 0.
- R8: Code 4'b0111 returns 1 in bit 0 when `a < b` as signed numbers and 0 otherwise. Bits 31..1 are 0. The comparison is correct even when `a - b` overflows, and `carry_out` follows the rule of R5.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R10: Any code outside {0000, 0001, 0010, 0110, 0111, 1100} returns a result of 0 with `overflow` and `carry_out` both 0.
- R11: For the logic codes 0000, 0001 and 1100, `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | All result bits are zero |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of bit 31 for add, subtract and less-than |

## Verification
The main corner is signed less-than with operands of opposite sign at the extremes, such as 0x7FFFFFFF against 0x80000000. A design that reads only the sign of the difference would return the inverted answer there. The bench also checks overflow at both ends of the signed range for add and subtract. A design that compared the wrong pair of carries would miss these cases or flag false overflows. Subtraction with equal operands and with a zero subtrahend is checked to catch a missing carry-in of one or an inverted borrow sense in `carry_out`. Unused codes are applied to expose a decoder that falls through to a live path and leaks a sum or a flag.

// File: rtl/alu_bs_pkg.sv
// Package: shared encodings for the bit-sliced ALU.
// Assumes a 4-bit operation code whose bit 3 inverts A and bit 2 inverts B.
package alu_bs_pkg;

    localparam int unsigned OP_W = 4;

    // Operation codes seen at the top-level port
    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    // Path chosen by each slice's result selector
    typedef enum logic [1:0] {
        PATH_AND  = 2'b00,
        PATH_OR   = 2'b01,
        PATH_SUM  = 2'b10,
        PATH_LESS = 2'b11
    } slice_path_e;

    // Control bundle fanned out to every slice and to the flag logic
    typedef struct packed {
        logic        a_inv;
        logic        b_inv;
        slice_path_e path;
        logic        valid;
        logic        arith;
        logic        carry_en;
    } slice_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
// Module: alu_op_decode
// Turns the 4-bit operation code into the slice controls and the flag enables.
// Assumes no hidden state. An unlisted code clears valid so that the top level
// forces a zero result.
module alu_op_decode
    import alu_bs_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output slice_ctrl_t     ctrl
);

    // Purpose: map each operation code onto the shared slice controls
    always_comb begin
        ctrl = '{a_inv: 1'b0, b_inv: 1'b0, path: PATH_AND,
                 valid: 1'b0, arith: 1'b0, carry_en: 1'b0};
        unique case (op_code)
            OP_AND: begin
                ctrl.path  = PATH_AND;
                ctrl.valid = 1'b1;
            end
            OP_OR: begin
                ctrl.path  = PATH_OR;
                ctrl.valid = 1'b1;
            end
            OP_NOR: begin
                ctrl.a_inv = 1'b1;
                ctrl.b_inv = 1'b1;
                ctrl.path  = PATH_AND;
                ctrl.valid = 1'b1;
            end
            OP_ADD: begin
                ctrl.path     = PATH_SUM;
                ctrl.valid    = 1'b1;
                ctrl.arith    = 1'b1;
                ctrl.carry_en = 1'b1;
            end
            OP_SUB: begin
                ctrl.b_inv    = 1'b1;
                ctrl.path     = PATH_SUM;
                ctrl.valid    = 1'b1;
                ctrl.arith    = 1'b1;
                ctrl.carry_en = 1'b1;
            end
            OP_SLT: begin
                ctrl.b_inv    = 1'b1;
                ctrl.path     = PATH_LESS;
                ctrl.valid    = 1'b1;
                ctrl.carry_en = 1'b1;
            end
            default: begin
                ctrl.valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
// Module: alu_slice
// One bit of the ALU: optional operand inverters, AND, OR, a full adder and a
// four-way result selector. Assumes the carry chain and the less input are
// wired by the parent.
module alu_slice
    import alu_bs_pkg::*;
(
    input  logic        a_bit,
    input  logic        b_bit,
    input  logic        a_inv,
    input  logic        b_inv,
    input  logic        carry_in,
    input  logic        less_in,
    input  slice_path_e path,
    output logic        res_bit,
    output logic        carry_out
);

    logic a_eff;
    logic b_eff;
    logic sum_bit;

    // Purpose: apply the operand inverters
    always_comb begin
        a_eff = a_bit ^ a_inv;
        b_eff = b_bit ^ b_inv;
    end

    // Purpose: full adder, sum and majority carry
    always_comb begin
        sum_bit   = a_eff ^ b_eff ^ carry_in;
        carry_out = (a_eff & b_eff) | (a_eff & carry_in) | (b_eff & carry_in);
    end

    // Purpose: pick the slice output
    always_comb begin
        unique case (path)
            PATH_AND:  res_bit = a_eff & b_eff;
            PATH_OR:   res_bit = a_eff | b_eff;
            PATH_SUM:  res_bit = sum_bit;
            PATH_LESS: res_bit = less_in;
            default:   res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_zero_detect.sv
// Module: alu_zero_detect
// Two-level OR reduction over the result word. The word is split into groups
// of GROUP bits; the group ORs are then combined. Assumes WIDTH >= 1.
module alu_zero_detect #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned GROUP = 4
) (
    input  logic [WIDTH-1:0] word,
    output logic             all_clear
);

    localparam int unsigned NGRP  = (WIDTH + GROUP - 1) / GROUP;
    localparam int unsigned PADW  = NGRP * GROUP;

    logic [PADW-1:0] padded;
    logic [NGRP-1:0] grp_any;

    // Purpose: widen the word to a whole number of groups
    always_comb begin
        padded             = '0;
        padded[WIDTH-1:0]  = word;
    end

    // Purpose: first-level OR in each group
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_any[g] = |padded[g*GROUP +: GROUP];
    end

    // Purpose: second-level combine
    assign all_clear = ~|grp_any;

endmodule

// File: rtl/alu32_bitslice.sv
// Module: alu32_bitslice
// Combinational ALU made from WIDTH replicated 1-bit slices on a ripple
// carry chain. Subtract and less-than inject carry 1 through the B inverter.
// The less-than bit is the sign of a-b corrected by signed overflow.
// Assumes operands are stable for the whole evaluation; there is no state.
module alu32_bitslice
    import alu_bs_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);

    localparam int unsigned MSB = WIDTH - 1;

    slice_ctrl_t      ctrl;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] slice_res;
    logic             msb_sum;
    logic             raw_ovf;
    logic             set_bit;

    alu_op_decode u_dec (
        .op_code (op),
        .ctrl    (ctrl)
    );

    // Purpose: carry-in of one for subtract and less-than
    assign carry[0] = ctrl.b_inv;

    // Purpose: signed compare bit from the top bit of the difference
    always_comb begin
        msb_sum = (a[MSB] ^ ctrl.a_inv) ^ (b[MSB] ^ ctrl.b_inv) ^ carry[MSB];
        raw_ovf = carry[MSB] ^ carry[WIDTH];
        set_bit = msb_sum ^ raw_ovf;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            alu_slice u_bit (
                .a_bit     (a[i]),
                .b_bit     (b[i]),
                .a_inv     (ctrl.a_inv),
                .b_inv     (ctrl.b_inv),
                .carry_in  (carry[i]),
                .less_in   (set_bit),
                .path      (ctrl.path),
                .res_bit   (slice_res[i]),
                .carry_out (carry[i+1])
            );
        end else begin : g_upper
            alu_slice u_bit (
                .a_bit     (a[i]),
                .b_bit     (b[i]),
                .a_inv     (ctrl.a_inv),
                .b_inv     (ctrl.b_inv),
                .carry_in  (carry[i]),
                .less_in   (1'b0),
                .path      (ctrl.path),
                .res_bit   (slice_res[i]),
                .carry_out (carry[i+1])
            );
        end
    end

    // Purpose: gate outputs and flags by the decoded operation class
    always_comb begin
        result    = ctrl.valid ? slice_res : '0;
        overflow  = ctrl.arith & raw_ovf;
        carry_out = ctrl.carry_en & carry[WIDTH];
    end

    alu_zero_detect #(
        .WIDTH (WIDTH),
        .GROUP (4)
    ) u_zero (
        .word      (result),
        .all_clear (zero)
    );

endmodule

// File: rtl/alu32_bitslice_chk.sv
// Module: alu32_bitslice_chk
// Port-level property checker bound to alu32_bitslice. The block has no
// clock, so every check is an immediate assertion on settled values.
module alu32_bitslice_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow,
    input logic             carry_out
);

    // Purpose: evaluate the port relations whenever any port changes
    always_comb begin
        // R9
        zero_flag_chk: assert (zero == (result == '0));
        if (op == 4'b0000) begin
            // R1
            and_path_chk: assert (result == (a & b));
        end
        if (op == 4'b1100) begin
            // R3
            nor_path_chk: assert (result == ~(a | b));
        end
        if (op != 4'b0010 && op != 4'b0110) begin
            // R7
            no_overflow_chk: assert (!overflow);
        end
        if (op == 4'b0010 && a[WIDTH-1] == b[WIDTH-1]) begin
            // R6
            add_ovf_chk: assert (overflow == (result[WIDTH-1] != a[WIDTH-1]));
        end
        if (op == 4'b0111) begin
            // R8
            slt_upper_chk: assert (result[WIDTH-1:1] == '0);
        end
        if (op == 4'b0000 || op == 4'b0001 || op == 4'b1100) begin
            // R11
            logic_carry_chk: assert (!carry_out);
        end
        if (!(op inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
            // R10
            bad_code_chk: assert (result == '0 && !overflow && !carry_out);
        end
    end

endmodule

bind alu32_bitslice alu32_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
    .a         (a),
    .b         (b),
    .op        (op),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow),
    .carry_out (carry_out)
);

// File: tb/alu32_bitslice_test.sv
// Bench: directed tasks per scenario plus a seeded sweep, all checked against
// a reference model written from the requirements.
module alu32_bitslice_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  op;
    logic [31:0] result;
    logic        zero;
    logic        overflow;
    logic        carry_out;

    int n_checks;
    int n_fail;
    bit finished;

    alu32_bitslice uut (
        .a         (a),
        .b         (b),
        .op        (op),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: returns {result, zero, overflow, carry_out}
    function automatic logic [34:0] ref_alu(input logic [31:0] x, input logic [31:0] y,
                                            input logic [3:0] code);
        logic [32:0] s;
        logic [31:0] r;
        logic        ov;
        logic        co;
        r = '0; ov = 1'b0; co = 1'b0;
        case (code)
            4'b0000: r = x & y;
            4'b0001: r = x | y;
            4'b1100: r = ~(x | y);
            4'b0010: begin
                s  = {1'b0, x} + {1'b0, y};
                r  = s[31:0];
                co = s[32];
                ov = (x[31] == y[31]) && (r[31] != x[31]);
            end
            4'b0110: begin
                r  = x - y;
                co = (x >= y);
                ov = (x[31] != y[31]) && (r[31] != x[31]);
            end
            4'b0111: begin
                r  = {31'b0, ($signed(x) < $signed(y))};
                co = (x >= y);
            end
            default: r = '0;
        endcase
        return {r, (r == 32'b0), ov, co};
    endfunction

    task automatic apply_check(input string tag, input logic [31:0] x, input logic [31:0] y,
                               input logic [3:0] code);
        logic [34:0] exp;
        a = x; b = y; op = code;
        #(CLK_PERIOD/2);
        exp = ref_alu(x, y, code);
        n_checks++;
        if ({result, zero, overflow, carry_out} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual res=%h z=%b ov=%b co=%b expected res=%h z=%b ov=%b co=%b",
                     tag, code, x, y, result, zero, overflow, carry_out,
                     exp[34:3], exp[2], exp[1], exp[0]);
        end
        #(CLK_PERIOD/2);
    endtask

    task automatic test_reset_state();
        apply_check("R9 reset", 32'h0, 32'h0, 4'b0000);
    endtask

    task automatic test_logic();
        apply_check("R1", 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0000);
        apply_check("R1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0000);
        apply_check("R2", 32'hF000_000F, 32'h0000_F0F0, 4'b0001);
        apply_check("R2 R11", 32'h0, 32'h0, 4'b0001);
        apply_check("R3", 32'hA5A5_0000, 32'h0000_5A5A, 4'b1100);
        apply_check("R3 R11", 32'hFFFF_FFFF, 32'h0, 4'b1100);
        apply_check("R3", 32'h0, 32'h0, 4'b1100);
    endtask

    task automatic test_add();
        apply_check("R4", 32'd100, 32'd23, 4'b0010);
        apply_check("R4", 32'hFFFF_FFFF, 32'h1, 4'b0010);
        apply_check("R6", 32'h7FFF_FFFF, 32'h1, 4'b0010);
        apply_check("R6", 32'h8000_0000, 32'h8000_0000, 4'b0010);
        apply_check("R6", 32'h7FFF_FFFF, 32'h8000_0000, 4'b0010);
    endtask

    task automatic test_sub();
        apply_check("R5", 32'd50, 32'd8, 4'b0110);
        apply_check("R5 R9", 32'h1234_5678, 32'h1234_5678, 4'b0110);
        apply_check("R5", 32'd3, 32'd0, 4'b0110);
        apply_check("R5", 32'd0, 32'd1, 4'b0110);
        apply_check("R6", 32'h8000_0000, 32'h1, 4'b0110);
        apply_check("R6", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110);
        apply_check("R6", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'b0110);
    endtask

    task automatic test_slt();
        apply_check("R8", 32'd5, 32'd9, 4'b0111);
        apply_check("R8", 32'd9, 32'd5, 4'b0111);
        apply_check("R8", 32'hFFFF_FFFF, 32'd1, 4'b0111);
        apply_check("R8", 32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
        apply_check("R8", 32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
        apply_check("R8", 32'h8000_0000, 32'h1, 4'b0111);
        apply_check("R8 R7", 32'd7, 32'd7, 4'b0111);
    endtask

    task automatic test_bad_codes();
        for (int c = 0; c < 16; c++) begin
            if (!(c inside {0, 1, 2, 6, 7, 12}))
                apply_check("R10", 32'h7FFF_FFFF, 32'h7FFF_FFFF, c[3:0]);
        end
    endtask

    task automatic test_sweep();
        logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b1100, 4'b0010, 4'b0110, 4'b0111};
        string      tags  [6] = '{"R1", "R2", "R3", "R4 R6", "R5 R6", "R8"};
        for (int k = 0; k < 6; k++) begin
            for (int n = 0; n < 300; n++) begin
                apply_check(tags[k], $urandom, $urandom, codes[k]);
            end
        end
    endtask

    initial begin
        n_checks = 0; n_fail = 0; finished = 0;
        a = '0; b = '0; op = '0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_logic();
        test_add();
        test_sub();
        test_slt();
        test_bad_codes();
        test_sweep();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule